// File: doc/BRIEF.md
# Banked Shadow Checkpoint Controller

This block manages a storage structure built from a fast volatile primary array and a slow non-volatile shadow array of identical size. Both arrays are cut into banks, and every bank carries its own copy engine. A save request copies the whole primary array into the shadow, with all banks running at once. A load request copies the shadow back into the primary array. A single pulse marks the end of each operation.

A shadow write takes several clock cycles, so during a save each bank engine holds each entry for a parameterised number of cycles before it moves on. A shadow read takes one cycle, so a load streams one entry per cycle per bank through a one-stage pipeline. When no copy is running, the primary array is open to a normal read/write port. That port is stalled while either copy runs.

Top module: `shadow_ckpt_ctrl`

## Requirements
- R1: After reset, `busy`, `done`, `err` and `rd_valid` are low and `acc_ready` is high.
- R2: When the block is idle, an accepted write stores `acc_wdata` at `acc_addr`. An accepted read returns the stored word on `rd_data`, with `rd_valid` high, in the next cycle. Address `a` maps to bank `a / BANK_DEPTH` and entry `a % BANK_DEPTH`.
- R3: When `save_req` is sampled while idle, `busy` rises in the next cycle. `done` pulses exactly `BANK_DEPTH*SHADOW_WR_CYCLES+1` cycles after the request edge, and `busy` falls in that same cycle.
- R4: While `busy` is high, `acc_ready` is low, and accesses have no effect: no write lands and no read returns data.
- R5: A completed load leaves the primary array holding exactly the contents it had when the last completed save ran, even if it was overwritten afterwards.
- R6: A load sampled while idle with a valid checkpoint pulses `done` exactly `BANK_DEPTH+2` cycles after the request edge.
- R7: A load sampled while idle with no completed save since reset starts no copy, leaves the primary array unchanged, and pulses `err` high for exactly one cycle in the next cycle.
- R8: `done` lasts one cycle. Save or load requests arriving while `busy` is high are ignored and do not lengthen the operation.
- R9: If `save_req` and `load_req` are sampled together while idle, the save runs and no error is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| save_req | input | 1 | Request to copy primary into shadow |
| load_req | input | 1 | Request to copy shadow into primary |
| busy | output | 1 | A save or load is in progress |
| done | output | 1 | One-cycle pulse when an operation completes |
| err | output | 1 | One-cycle pulse for a load with no valid checkpoint |
| acc_valid | input | 1 | Normal access request |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | ADDR_W | Flat entry address |
| acc_wdata | input | DATA_W | Write data |
| acc_ready | output | 1 | Access accepted this cycle |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | DATA_W | Read data |

## Verification
The bench goes after the timing edges of both copy modes. A design that counts shadow-wait cycles one too few or one too many moves the `done` edge. A design that fails to pipeline the shadow read writes stale or shifted words during a load. The bench also attempts a load before any save exists, where a faulty design would copy uninitialised shadow contents or leave `err` high. It injects writes and extra requests in the middle of a save: a design that still accepts them would corrupt the checkpoint or stretch `busy`. Finally it raises both requests in the same cycle to expose a wrong priority choice.

// File: rtl/ckpt_pkg.sv
package ckpt_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_SAVE = 2'd1,
    SEQ_LOAD = 2'd2
  } seq_state_e;
endpackage

// File: rtl/ckpt_seq.sv
module ckpt_seq
  import ckpt_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       save_req,
  input  logic       load_req,
  input  logic       all_fin,
  output seq_state_e state,
  output logic       start_save,
  output logic       start_load,
  output logic       done,
  output logic       err
);
  seq_state_e state_d;
  logic       ckpt_ok, ckpt_ok_d, done_d, err_d, idle;

  always_comb begin
    idle       = (state == SEQ_IDLE);
    start_save = idle && save_req;
    start_load = idle && !save_req && load_req && ckpt_ok;
    err_d      = idle && !save_req && load_req && !ckpt_ok;
    done_d     = !idle && all_fin;
    ckpt_ok_d  = ckpt_ok || ((state == SEQ_SAVE) && all_fin);
    state_d    = state;
    if (start_save)      state_d = SEQ_SAVE;
    else if (start_load) state_d = SEQ_LOAD;
    else if (done_d)     state_d = SEQ_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= SEQ_IDLE;
      ckpt_ok <= 1'b0;
      done    <= 1'b0;
      err     <= 1'b0;
    end else begin
      state   <= state_d;
      ckpt_ok <= ckpt_ok_d;
      done    <= done_d;
      err     <= err_d;
    end
  end
endmodule

// File: rtl/ckpt_bank.sv
module ckpt_bank #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 4,
  parameter int SH_LAT = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_save,
  input  logic              start_load,
  input  logic              acc_we,
  input  logic [IDX_W-1:0]  acc_idx,
  input  logic [DATA_W-1:0] acc_wdata,
  output logic [DATA_W-1:0] acc_rword,
  output logic              fin
);
  localparam int IDX_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int WAIT_W = (SH_LAT > 1) ? $clog2(SH_LAT) : 1;
  localparam logic [IDX_W-1:0]  LAST_IDX = IDX_W'(DEPTH - 1);
  localparam logic [WAIT_W-1:0] WAIT_TOP = WAIT_W'(SH_LAT - 1);

  logic [DATA_W-1:0] prim_mem [DEPTH];
  logic [DATA_W-1:0] shad_mem [DEPTH];

  logic              save_act, save_act_d, load_act, load_act_d;
  logic [IDX_W-1:0]  idx, idx_d, ridx;
  logic [WAIT_W-1:0] wait_cnt, wait_d;
  logic              rvld, fin_d, commit, last;
  logic [DATA_W-1:0] rbuf;

  always_comb begin
    last       = (idx == LAST_IDX);
    commit     = save_act && (wait_cnt == '0);
    fin_d      = (commit && last) || (rvld && (ridx == LAST_IDX));
    save_act_d = save_act;
    load_act_d = load_act;
    idx_d      = idx;
    wait_d     = wait_cnt;
    if (start_save || start_load) begin
      idx_d      = '0;
      wait_d     = WAIT_TOP;
      save_act_d = start_save;
      load_act_d = start_load;
    end else begin
      if (save_act) begin
        wait_d = (wait_cnt == '0) ? WAIT_TOP : wait_cnt - 1'b1;
        if (commit) begin
          if (last) save_act_d = 1'b0;
          else      idx_d      = idx + 1'b1;
        end
      end
      if (load_act) begin
        if (last) load_act_d = 1'b0;
        else      idx_d      = idx + 1'b1;
      end
    end
    acc_rword = prim_mem[acc_idx];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      save_act <= 1'b0;
      load_act <= 1'b0;
      idx      <= '0;
      wait_cnt <= '0;
      rvld     <= 1'b0;
      ridx     <= '0;
      fin      <= 1'b0;
    end else begin
      save_act <= save_act_d;
      load_act <= load_act_d;
      idx      <= idx_d;
      wait_cnt <= wait_d;
      rvld     <= load_act;
      if (load_act) ridx <= idx;
      fin      <= fin_d;
    end
  end

  // storage: behavioural arrays, no reset
  always_ff @(posedge clk) begin
    if (commit)        shad_mem[idx]  <= prim_mem[idx];
    if (load_act)      rbuf           <= shad_mem[idx];
    if (rvld)          prim_mem[ridx] <= rbuf;
    else if (acc_we)   prim_mem[acc_idx] <= acc_wdata;
  end
endmodule

// File: rtl/shadow_ckpt_ctrl.sv
module shadow_ckpt_ctrl
  import ckpt_pkg::*;
#(
  parameter int NUM_BANKS        = 8,
  parameter int BANK_DEPTH       = 4,
  parameter int DATA_W           = 16,
  parameter int SHADOW_WR_CYCLES = 3,
  localparam int TOTAL  = NUM_BANKS * BANK_DEPTH,
  localparam int ADDR_W = (TOTAL > 1) ? $clog2(TOTAL) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              save_req,
  input  logic              load_req,
  output logic              busy,
  output logic              done,
  output logic              err,
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [DATA_W-1:0] acc_wdata,
  output logic              acc_ready,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data
);
  localparam int IDX_W = (BANK_DEPTH > 1) ? $clog2(BANK_DEPTH) : 1;
  localparam logic [ADDR_W-1:0] DEPTH_A = ADDR_W'(BANK_DEPTH);

  seq_state_e        state;
  logic              start_save, start_load, all_fin;
  logic [NUM_BANKS-1:0] fin_vec;
  logic [DATA_W-1:0] bank_word [NUM_BANKS];
  logic [ADDR_W-1:0] bank_num;
  logic [IDX_W-1:0]  acc_idx;
  logic [DATA_W-1:0] rd_sel;
  logic              rd_take;

  ckpt_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .save_req   (save_req),
    .load_req   (load_req),
    .all_fin    (all_fin),
    .state      (state),
    .start_save (start_save),
    .start_load (start_load),
    .done       (done),
    .err        (err)
  );

  always_comb begin
    busy      = (state != SEQ_IDLE);
    acc_ready = !busy;
    all_fin   = &fin_vec;
    bank_num  = acc_addr / DEPTH_A;
    acc_idx   = IDX_W'(acc_addr % DEPTH_A);
    rd_take   = acc_valid && !acc_write && acc_ready;
    rd_sel    = '0;
    for (int b = 0; b < NUM_BANKS; b++)
      if (bank_num == ADDR_W'(b)) rd_sel = bank_word[b];
  end

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    logic we;
    assign we = acc_valid && acc_write && acc_ready && (bank_num == ADDR_W'(g));
    ckpt_bank #(
      .DATA_W (DATA_W),
      .DEPTH  (BANK_DEPTH),
      .SH_LAT (SHADOW_WR_CYCLES)
    ) u_bank (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_save (start_save),
      .start_load (start_load),
      .acc_we     (we),
      .acc_idx    (acc_idx),
      .acc_wdata  (acc_wdata),
      .acc_rword  (bank_word[g]),
      .fin        (fin_vec[g])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_valid <= 1'b0;
    else        rd_valid <= rd_take;
  end

  always_ff @(posedge clk) begin
    if (rd_take) rd_data <= rd_sel;
  end
endmodule

// File: rtl/shadow_ckpt_ctrl_sva.sv
module shadow_ckpt_ctrl_sva (
  input logic clk,
  input logic rst_n,
  input logic save_req,
  input logic load_req,
  input logic busy,
  input logic done,
  input logic err,
  input logic rd_valid
);
  assert_busy_blocks_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !rd_valid);
  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_done_ends_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> (!busy && $past(busy)));
  assert_save_starts_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && save_req) |=> busy);
  assert_err_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> !err);
  assert_err_no_copy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !busy);
  assert_save_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && save_req && load_req) |=> (busy && !err));
endmodule

bind shadow_ckpt_ctrl shadow_ckpt_ctrl_sva u_sva (
  .clk      (clk),
  .rst_n    (rst_n),
  .save_req (save_req),
  .load_req (load_req),
  .busy     (busy),
  .done     (done),
  .err      (err),
  .rd_valid (rd_valid)
);

// File: tb/sim_shadow_ckpt_ctrl.sv
`timescale 1ns/1ps
module sim_shadow_ckpt_ctrl;
  localparam int NB = 8, DEP = 4, DW = 16, LAT = 3;
  localparam int TOT = NB * DEP;
  localparam int AW = $clog2(TOT);
  localparam int SAVE_LEN = DEP * LAT + 1;
  localparam int LOAD_LEN = DEP + 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic save_req = 0, load_req = 0, acc_valid = 0, acc_write = 0;
  logic [AW-1:0] acc_addr = '0;
  logic [DW-1:0] acc_wdata = '0;
  logic busy, done, err, acc_ready, rd_valid;
  logic [DW-1:0] rd_data;

  always #2.5 clk = ~clk;

  shadow_ckpt_ctrl #(.NUM_BANKS(NB), .BANK_DEPTH(DEP), .DATA_W(DW),
                     .SHADOW_WR_CYCLES(LAT)) u0 (
    .clk(clk), .rst_n(rst_n), .save_req(save_req), .load_req(load_req),
    .busy(busy), .done(done), .err(err), .acc_valid(acc_valid),
    .acc_write(acc_write), .acc_addr(acc_addr), .acc_wdata(acc_wdata),
    .acc_ready(acc_ready), .rd_valid(rd_valid), .rd_data(rd_data));

  int errors = 0, checks = 0;
  string rd_tag = "R2";
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  // behavioural reference model
  logic [DW-1:0] prim_m [TOT];
  logic [DW-1:0] shad_m [TOT];
  bit m_valid = 0, m_busy = 0, m_save = 0;
  int m_cnt = 0;
  bit e_done, e_err, e_rdv;
  logic [DW-1:0] e_rd;

  initial begin
    forever begin
      @(posedge clk);
      if (rst_n) begin
        e_done = 0; e_err = 0; e_rdv = 0;
        if (m_busy) begin
          m_cnt--;
          if (m_cnt == 0) begin
            m_busy = 0; e_done = 1;
            for (int i = 0; i < TOT; i++)
              if (m_save) shad_m[i] = prim_m[i]; else prim_m[i] = shad_m[i];
            if (m_save) m_valid = 1;
          end
        end else begin
          if (acc_valid) begin
            if (acc_write) prim_m[acc_addr] = acc_wdata;
            else begin e_rdv = 1; e_rd = prim_m[acc_addr]; end
          end
          if (save_req) begin m_busy = 1; m_save = 1; m_cnt = SAVE_LEN; end
          else if (load_req) begin
            if (m_valid) begin m_busy = 1; m_save = 0; m_cnt = LOAD_LEN; end
            else e_err = 1;
          end
        end
        #1;
        chk(busy == m_busy, "R3", "busy", busy, m_busy);
        chk(acc_ready == !m_busy, "R4", "acc_ready", acc_ready, !m_busy);
        chk(done == e_done, m_save ? "R3" : "R6", "done", done, e_done);
        chk(err == e_err, "R7", "err", err, e_err);
        chk(rd_valid == e_rdv, rd_tag, "rd_valid", rd_valid, e_rdv);
        if (e_rdv) chk(rd_data == e_rd, rd_tag, "rd_data", rd_data, e_rd);
      end
    end
  end

  task automatic put(input bit v, input bit w, input int a, input int d,
                     input bit sr, input bit lr);
    @(negedge clk);
    acc_valid = v; acc_write = w; acc_addr = AW'(a); acc_wdata = DW'(d);
    save_req = sr; load_req = lr;
  endtask

  task automatic idle1();
    put(0, 0, 0, 0, 0, 0);
  endtask

  // start an operation, optionally poke it while busy, measure to done
  task automatic run_op(input bit sr, input bit lr, input int exp_len,
                        input bit poke, input string req);
    int k = 0;
    put(0, 0, 0, 0, sr, lr);
    while (k < 1000) begin
      k++;
      if (poke && k == 2) put(1, 1, 5, 16'hDEAD, 0, 0);
      else if (poke && k == 3) put(0, 0, 0, 0, 1, 1);
      else idle1();
      if (done) break;
    end
    chk(k == exp_len + 1, req, "cycles to done", k - 1, exp_len);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    // R1 reset state
    chk(!busy && !done && !err && !rd_valid, "R1", "idle outputs",
        {busy, done, err, rd_valid}, 0);
    chk(acc_ready, "R1", "acc_ready", acc_ready, 1);
    @(negedge clk); rst_n = 1;
    // R2 fill and read back
    for (int i = 0; i < TOT; i++) put(1, 1, i, 16'h1000 + i * 7, 0, 0);
    for (int i = 0; i < TOT; i++) put(1, 0, TOT - 1 - i, 0, 0, 0);
    idle1();
    // R7 load with no checkpoint, then verify primary untouched
    put(0, 0, 0, 0, 0, 1);
    idle1();
    chk(err, "R7", "err pulse", err, 1);
    idle1();
    chk(!err && !busy, "R7", "err one cycle", {err, busy}, 0);
    for (int i = 0; i < TOT; i += 3) put(1, 0, i, 0, 0, 0);
    idle1();
    // R3 save with R4/R8 pokes during busy
    run_op(1, 0, SAVE_LEN, 1, "R3");
    idle1();
    chk(!done, "R8", "done single", done, 0);
    rd_tag = "R4";
    put(1, 0, 5, 0, 0, 0); idle1();
    chk(rd_data == 16'h1000 + 5 * 7, "R4", "poked word", rd_data, 16'h1000 + 35);
    rd_tag = "R2";
    // overwrite everything
    for (int i = 0; i < TOT; i++) put(1, 1, i, 16'hA000 ^ (i * 13), 0, 0);
    idle1();
    // R5/R6 load restores the checkpoint
    run_op(0, 1, LOAD_LEN, 0, "R6");
    rd_tag = "R5";
    for (int i = 0; i < TOT; i++) put(1, 0, i, 0, 0, 0);
    idle1();
    rd_tag = "R2";
    // R9 both requests together: save runs
    for (int i = 0; i < TOT; i += 2) put(1, 1, i, 16'h5500 + i, 0, 0);
    run_op(1, 1, SAVE_LEN, 0, "R9");
    for (int i = 0; i < TOT; i++) put(1, 1, i, 16'h0F0F, 0, 0);
    run_op(0, 1, LOAD_LEN, 0, "R5");
    rd_tag = "R5";
    for (int i = 0; i < TOT; i++) put(1, 0, i, 0, 0, 0);
    idle1(); idle1();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog R3 actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule